// File: doc/BRIEF.md
# Per-Channel Interrupt Flag Bank for a Five-Channel DMA

This block collects the event pulses of five DMA channels and turns them into sticky status flags that software can inspect and acknowledge. Every channel reports three kinds of event as single-cycle pulses: a transfer error, reaching the halfway point of a transfer, and completing a transfer. Each pulse sets its own flag, and any of the three also sets a per-channel summary flag. That summary flag drives the channel's interrupt line.

Software reads all flags from one read-only status word at byte offset 0x00. It acknowledges flags by writing ones to a separate clear word at byte offset 0x04. Both words accept 8-bit, 16-bit and 32-bit writes, and only the byte lanes the access enables take part. The summary flag is a bit of its own, so it is acknowledged separately from the three event flags. When a hardware event and a software acknowledge reach the same flag in the same cycle, the event wins.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset the status word reads 0x0000_0000 and every interrupt output is 0.
- R2: Channel c (0..4) owns status bits [4c+3:4c]. Bit 4c is the summary flag, bit 4c+1 is the done flag, bit 4c+2 is the halfway flag and bit 4c+3 is the error flag. An event pulse in a cycle sets its flag and the channel's summary flag at the next clock edge.
- R3: Flags are sticky. A write to offset 0x00, with any data and any lane enables, changes no flag.
- R4: A write to offset 0x04 clears every flag whose bit position holds a 1 in an enabled byte lane. Zero bits leave their flags unchanged. The summary flag clears only through its own bit.
- R5: Byte enable bit b gates data bits [8b+7:8b]. Bits in disabled lanes clear nothing.
- R6: When an event and a clear hit the same flag in the same cycle, the flag is 1 afterwards.
- R7: Status bits 31:20 always read 0, including after all events fire and after ones are written there.
- R8: Interrupt output c equals the summary flag of channel c.
- R9: A read returns its data on bus_rdata one cycle after the access. Reads of offset 0x04 or any unmapped offset (0x08, 0x0C) return 0, and writes to unmapped offsets change no flag. bus_rdata is 0 in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset; bits 1:0 ignored |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| ev_err | input | NCH (5) | Transfer error pulse per channel |
| ev_half | input | NCH (5) | Halfway pulse per channel |
| ev_done | input | NCH (5) | Transfer done pulse per channel |
| irq | output | NCH (5) | Interrupt per channel |

## Verification
A hardware event and a software acknowledge can reach the same flag in the same clock cycle. The bench sets a channel's done and summary flags first. It then drives a done pulse on that channel in the same cycle as a full-width write of ones to those bits of the clear word, and expects the next status read to still show both flags. A follow-up acknowledge with no event pending must then clear them, which shows that the clear path itself works.

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int NCH    = 5,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ev_err,
  input  logic [NCH-1:0]    ev_half,
  input  logic [NCH-1:0]    ev_done,
  output logic [NCH-1:0]    irq
);
  localparam int USED = 4 * NCH;
  localparam int WSEL = ADDR_W - 2;

  logic [USED-1:0] flag_q;
  logic [USED-1:0] set_v;
  logic [31:0]     lane_mask;

  wire acc_wr   = bus_sel & bus_wr;
  wire acc_rd   = bus_sel & ~bus_wr;
  wire hit_stat = bus_addr[ADDR_W-1:2] == WSEL'(0);
  wire hit_clr  = bus_addr[ADDR_W-1:2] == WSEL'(1);

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{bus_be[b]}};
  end

  wire [31:0] clr_word = (acc_wr && hit_clr) ? (bus_wdata & lane_mask) : 32'h0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign set_v[4*c +: 4] = {ev_err[c], ev_half[c], ev_done[c],
                              ev_err[c] | ev_half[c] | ev_done[c]};
    assign irq[c] = flag_q[4*c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_word[USED-1:0]) | set_v;
  end

  wire [31:0] status = {{(32-USED){1'b0}}, flag_q};

  always_ff @(posedge clk) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (acc_rd && hit_stat) bus_rdata <= status;
    else                         bus_rdata <= '0;
  end
endmodule

module dma_irq_flags_chk #(
  parameter int NCH    = 5,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    ev_err,
  input logic [NCH-1:0]    ev_half,
  input logic [NCH-1:0]    ev_done,
  input logic [NCH-1:0]    irq,
  input logic [4*NCH-1:0]  flag_q
);
  localparam int WSEL = ADDR_W - 2;

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err[c] |=> flag_q[4*c+3] && flag_q[4*c]);
    p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done[c] |=> flag_q[4*c+1]);
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_err[c] || ev_half[c] || ev_done[c]) |=> irq[c]);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[4*c] && !(bus_sel && bus_wr)) |=> flag_q[4*c]);
  end

  p_stat_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == WSEL'(0))
      |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1:2] != WSEL'(0)) |=> bus_rdata == 32'h0);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> bus_rdata == 32'h0);
  p_resv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:4*NCH] == '0);
endmodule

bind dma_irq_flags dma_irq_flags_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ev_err(ev_err),
  .ev_half(ev_half), .ev_done(ev_done), .irq(irq), .flag_q(flag_q)
);

// File: tb/tb_dma_irq_flags.sv
module tb_dma_irq_flags;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0, bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [4:0]  ev_err = 0, ev_half = 0, ev_done = 0;
  logic [4:0]  irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend_q = 0;

  always #5 clk = ~clk;

  dma_irq_flags dut (.*);

  always @(posedge clk) pend_q <= bus_sel & ~bus_wr;

  always @(negedge clk) begin
    if (pend_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s rdata=%h exp=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse(input logic [4:0] e, input logic [4:0] h, input logic [4:0] d);
    @(negedge clk);
    ev_err = e; ev_half = h; ev_done = d;
    @(negedge clk);
    ev_err = 0; ev_half = 0; ev_done = 0;
  endtask

  task automatic chk_irq(input logic [4:0] e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq=%b exp=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_irq(5'b0, "R1 irq after reset");
    rd(4'h0, 32'h0, "R1 status after reset");

    pulse(5'b00000, 5'b00000, 5'b00001);
    pulse(5'b00000, 5'b00100, 5'b00000);
    pulse(5'b10000, 5'b00000, 5'b00000);
    rd(4'h0, 32'h0009_0503, "R2 event layout");
    chk_irq(5'b10101, "R8 irq follows summary");

    wr(4'h0, 4'hF, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0009_0503, "R3 status write ignored");
    wr(4'h8, 4'hF, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0009_0503, "R9 unmapped write ignored");
    rd(4'h8, 32'h0, "R9 unmapped read zero");
    rd(4'h4, 32'h0, "R9 clear word reads zero");

    wr(4'h4, 4'h1, 32'h0000_0002);
    rd(4'h0, 32'h0009_0501, "R4 clear done only");
    chk_irq(5'b10101, "R4 summary kept");
    wr(4'h4, 4'h1, 32'h0000_0001);
    rd(4'h0, 32'h0009_0500, "R4 clear summary");
    chk_irq(5'b10100, "R8 irq drops with summary");

    wr(4'h4, 4'hD, 32'h0000_0500);
    rd(4'h0, 32'h0009_0500, "R5 disabled lane no clear");
    wr(4'h4, 4'h2, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0009_0000, "R5 byte lane 1 clear");
    wr(4'h4, 4'hC, 32'h0009_0000);
    rd(4'h0, 32'h0, "R5 halfword clear");
    chk_irq(5'b0, "R8 all irq low");

    pulse(5'b00000, 5'b00000, 5'b00010);
    rd(4'h0, 32'h0000_0030, "R2 channel 1 done");
    @(negedge clk);
    ev_done = 5'b00010;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_be = 4'hF; bus_wdata = 32'h30;
    @(negedge clk);
    ev_done = 0; bus_sel = 0; bus_wr = 0;
    rd(4'h0, 32'h0000_0030, "R6 set wins over clear");
    wr(4'h4, 4'hF, 32'h30);
    rd(4'h0, 32'h0, "R6 later clear works");

    pulse(5'h1F, 5'h1F, 5'h1F);
    rd(4'h0, 32'h000F_FFFF, "R7 all events, reserved zero");
    chk_irq(5'h1F, "R8 all irq high");
    wr(4'h4, 4'hF, 32'hFFF0_0000);
    rd(4'h0, 32'h000F_FFFF, "R7 reserved clear no effect");
    wr(4'h4, 4'hF, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0, "R4 full clear");
    chk_irq(5'b0, "R1 irq low again");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule